// File: doc/BRIEF.md
# Multiplexed Address/Data Host Bus Front End

This block sits between a host processor and a two-channel serial controller. The host reaches it over one shared 8-bit bus that carries an address first and data after it. An active-low address strobe marks the address phase. While that strobe is low, the byte on the bus is taken into an address latch. Once the strobe returns high, the access is in its data phase. Active-low chip select, read and write strobes then move one byte to or from the register that the latched address names.

The block turns host activity into single-cycle register strobes for the internal register files, together with the write byte, a register offset and a read return path that has an output enable for the pad. Bit 6 of the latched address chooses one of the two channels. All other address bits form the register offset, which goes to both channels unchanged. Every host input passes through a two-flop synchroniser before edge detection, so each strobe appears three clock cycles after the host edge. A low-power input stops the block from responding to the bus. When that input is released, the block gives the channels a reset pulse of fixed length.

Top module: `mbus_host_if`

## Requirements
- R1: While the synchronised address strobe is low and the block is not gated, the latch takes the bus byte, and reg_ofs shows that byte with bit 6 removed, as {bit7, bits5..0}, three cycles after the host drives it. While the address strobe is high, reg_ofs does not change.
- R2: Latched address bit 6 selects the target channel. A value of 0 drives strobe index 0 (channel A) and a value of 1 drives strobe index 1 (channel B). The other index never pulses.
- R3: A falling edge of rd_n in the data phase with cs_n low produces exactly one rd_stb pulse, one cycle wide, in the third cycle after the edge.
- R4: A rising edge of wr_n in the data phase with cs_n low produces exactly one wr_stb pulse, one cycle wide, in the third cycle after the edge. In that same cycle wr_data holds the bus byte present at the rising edge. The falling edge of wr_n produces no strobe.
- R5: While cs_n is high, no read or write strobe is produced and bus_oe stays low.
- R6: bus_oe is high only while cs_n and rd_n are low in the data phase, with the same three-cycle lag. While it is high, bus_out carries the selected channel's read byte. Otherwise bus_out is zero.
- R7: Read and write edges that occur while the address strobe is low produce no strobes.
- R8: While lp_in is high, no address is latched, no strobe is produced and bus_oe stays low.
- R9: A falling edge of lp_in raises chan_rst for RST_CYC consecutive cycles (default 4), starting three cycles after the edge. The address latch is cleared to zero during this pulse, and bus activity stays gated.
- R10: After rst_n, all strobes, bus_oe, bus_out, reg_ofs and chan_rst are zero.
- R11: At most one of the four strobe bits is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_in | input | 1 | Low-power request, active high |
| ale_n | input | 1 | Address strobe, low = address phase |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Shared address/data bus, inbound |
| bus_out | output | 8 | Read data toward the bus |
| bus_oe | output | 1 | Output enable for bus_out |
| reg_ofs | output | 7 | Latched register offset, sent to both channels |
| wr_stb | output | 2 | Per-channel write strobe (index 0 = A) |
| rd_stb | output | 2 | Per-channel read strobe (index 0 = A) |
| wr_data | output | 8 | Byte to be written |
| rd_data_a | input | 8 | Channel A read byte |
| rd_data_b | input | 8 | Channel B read byte |
| chan_rst | output | 1 | Reset pulse to both channels after low-power exit |

## Verification
Reads and writes are issued to random addresses with random data and random channel read bytes. Because both values of bit 6 occur, any wrong channel steering or wrong offset packing shows up. Directed cases then repeat the same strobes under conditions that must suppress them: chip select held high, an edge arriving in the address phase, the write falling edge, and low power active. Each of these separates an unqualified strobe path from a correctly gated one. The low-power release case measures the start cycle and the length of the reset pulse and confirms that the address latch has been cleared.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int BUS_W    = 8;
  localparam int CHAN_BIT = 6;
  localparam int OFS_W    = BUS_W - 1;
  localparam int NUM_CH   = 2;
  localparam int CTL_W    = 5;   // wr, rd, lp, cs, ale
  localparam int EDGE_W   = 3;   // wr, rd, lp need edge detection

  function automatic logic [OFS_W-1:0] offset_of(input logic [BUS_W-1:0] a);
    logic [OFS_W-1:0] o;
    o = '0;
    for (int i = 0; i < BUS_W; i++) begin
      if (i < CHAN_BIT)      o[i]   = a[i];
      else if (i > CHAN_BIT) o[i-1] = a[i];
    end
    return o;
  endfunction

  function automatic logic chan_of(input logic [BUS_W-1:0] a);
    return a[CHAN_BIT];
  endfunction

  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic fall_of(input logic cur, input logic prev);
    return prev & ~cur;
  endfunction
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int          W      = 8,
  parameter int          EDGE_W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      d,
  output logic [W-1:0]      q,
  output logic [EDGE_W-1:0] q_prev
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= RST_VAL;
      q      <= RST_VAL;
      q_prev <= RST_VAL[EDGE_W-1:0];
    end else begin
      s1     <= d;
      q      <= s1;
      q_prev <= q[EDGE_W-1:0];
    end
  end
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/mbus_lp_rst.sv
module mbus_lp_rst #(
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_fall,
  output logic rst_pulse
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (lp_fall)      cnt <= LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign rst_pulse = (cnt != '0);
endmodule

// File: rtl/mbus_host_if.sv
module mbus_host_if
  import mbus_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_in,
  input  logic              ale_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic [OFS_W-1:0]  reg_ofs,
  output logic [NUM_CH-1:0] wr_stb,
  output logic [NUM_CH-1:0] rd_stb,
  output logic [BUS_W-1:0]  wr_data,
  input  logic [BUS_W-1:0]  rd_data_a,
  input  logic [BUS_W-1:0]  rd_data_b,
  output logic              chan_rst
);
  localparam int SW = CTL_W + BUS_W;
  localparam logic [SW-1:0] SYNC_RST = {{BUS_W{1'b0}}, 5'b11011};

  logic [SW-1:0]     raw, sq;
  logic [EDGE_W-1:0] sp;

  assign raw = {bus_in, ale_n, cs_n, lp_in, rd_n, wr_n};

  mbus_sync #(.W(SW), .EDGE_W(EDGE_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(sq), .q_prev(sp)
  );

  logic             wr_s, rd_s, lp_s, cs_s, ale_s;
  logic [BUS_W-1:0] bus_s;
  assign wr_s  = sq[0];
  assign rd_s  = sq[1];
  assign lp_s  = sq[2];
  assign cs_s  = sq[3];
  assign ale_s = sq[4];
  assign bus_s = sq[SW-1:CTL_W];

  // named internal events
  logic wr_rise, rd_fall, lp_fall;
  logic lp_gate, data_ph, addr_load, addr_clr;
  logic rd_hit, wr_hit, oe_nxt;

  assign wr_rise = rise_of(wr_s, sp[0]);
  assign rd_fall = fall_of(rd_s, sp[1]);
  assign lp_fall = fall_of(lp_s, sp[2]);

  mbus_lp_rst #(.RST_CYC(RST_CYC)) u_lp (
    .clk(clk), .rst_n(rst_n), .lp_fall(lp_fall), .rst_pulse(chan_rst)
  );

  assign lp_gate   = lp_s | chan_rst;
  assign addr_clr  = chan_rst;
  assign addr_load = ~ale_s & ~lp_gate;
  assign data_ph   = ale_s & ~cs_s & ~lp_gate;
  assign rd_hit    = data_ph & rd_fall;
  assign wr_hit    = data_ph & wr_rise;
  assign oe_nxt    = data_ph & ~rd_s;

  logic [BUS_W-1:0] addr_q;

  mbus_addr_latch #(.W(BUS_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .clr(addr_clr),
    .d(bus_s), .q(addr_q)
  );

  logic sel;
  assign sel     = chan_of(addr_q);
  assign reg_ofs = offset_of(addr_q);

  logic [NUM_CH-1:0] rd_nxt, wr_nxt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rd_nxt[c] = rd_hit & (sel == c[0]);
    assign wr_nxt[c] = wr_hit & (sel == c[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb  <= '0;
      wr_stb  <= '0;
      bus_oe  <= 1'b0;
      wr_data <= '0;
    end else begin
      rd_stb <= rd_nxt;
      wr_stb <= wr_nxt;
      bus_oe <= oe_nxt;
      if (wr_hit) wr_data <= bus_s;
    end
  end

  always_comb begin
    bus_out = '0;
    if (bus_oe) bus_out = sel ? rd_data_b : rd_data_a;
  end
endmodule

// File: rtl/mbus_host_if_chk.sv
module mbus_host_if_chk
  import mbus_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] wr_stb,
  input logic [NUM_CH-1:0] rd_stb,
  input logic              bus_oe,
  input logic [BUS_W-1:0]  bus_out,
  input logic [OFS_W-1:0]  reg_ofs,
  input logic              chan_rst,
  input logic              lp_gate,
  input logic              lp_fall,
  input logic              addr_load,
  input logic              addr_clr
);
  localparam int CW = $clog2(RST_CYC + 2);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (chan_rst) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb})); // R11
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_stb) |=> !(|rd_stb)); // R3
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |=> !(|wr_stb)); // R4
  AST_LP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lp_gate |=> (!bus_oe && rd_stb == '0 && wr_stb == '0)); // R8
  AST_OE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0)); // R6
  AST_RST_START: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fall |=> chan_rst); // R9
  AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_rst) |-> (run_len == CW'(RST_CYC))); // R9
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && !addr_clr) |=> $stable(reg_ofs)); // R1
endmodule

bind mbus_host_if mbus_host_if_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .bus_oe(bus_oe), .bus_out(bus_out), .reg_ofs(reg_ofs),
  .chan_rst(chan_rst), .lp_gate(lp_gate), .lp_fall(lp_fall),
  .addr_load(addr_load), .addr_clr(addr_clr)
);

// File: tb/mbus_host_if_tb.sv
module mbus_host_if_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lp_in = 1'b0, ale_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] bus_in = '0, rd_data_a = '0, rd_data_b = '0;
  logic [7:0] bus_out, wr_data;
  logic       bus_oe, chan_rst;
  logic [6:0] reg_ofs;
  logic [1:0] wr_stb, rd_stb;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  mbus_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .lp_in(lp_in), .ale_n(ale_n), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .reg_ofs(reg_ofs), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .chan_rst(chan_rst)
  );

  function automatic logic [6:0] exp_ofs(input logic [7:0] a);
    return 7'(((a >> 1) & 8'h40) | (a & 8'h3F));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_addr(input logic [7:0] a);
    @(negedge clk); ale_n = 1'b0; bus_in = a;
    repeat (4) @(negedge clk);
    ale_n = 1'b1; bus_in = ~a;
    repeat (4) @(negedge clk);
    chk(reg_ofs == exp_ofs(a), "R1", "offset after latch/hold", reg_ofs, exp_ofs(a));
  endtask

  task automatic run_read(input logic [7:0] a);
    int n0 = 0, n1 = 0, first = 0, nw = 0;
    logic [7:0] exp_d;
    set_addr(a);
    rd_data_a = 8'($urandom); rd_data_b = 8'($urandom);
    exp_d = a[6] ? rd_data_b : rd_data_a;
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (rd_stb[0]) n0++;
      if (rd_stb[1]) n1++;
      if (wr_stb != 0) nw++;
      if (rd_stb != 0 && first == 0) first = k;
      if (k == 5) begin
        chk(bus_oe == 1'b1, "R6", "oe during read", bus_oe, 1);
        chk(bus_out == exp_d, "R6", "read return byte", bus_out, exp_d);
      end
    end
    chk(n0 == (a[6] ? 0 : 1) && n1 == (a[6] ? 1 : 0), "R2", "read channel pulses",
        {n1[15:0], n0[15:0]}, a[6] ? 32'h10000 : 32'h1);
    chk(first == 3, "R3", "read strobe cycle", first, 3);
    chk(nw == 0, "R11", "no write during read", nw, 0);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_oe == 1'b0 && bus_out == 8'h00, "R6", "oe off after read", bus_oe, 0);
  endtask

  task automatic run_write(input logic [7:0] a, input logic [7:0] d);
    int n0 = 0, n1 = 0, first = 0, early = 0;
    logic [7:0] got = '0;
    set_addr(a);
    @(negedge clk); cs_n = 1'b0; bus_in = d; wr_n = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (wr_stb != 0) early++;
    end
    chk(early == 0, "R4", "no strobe on write falling edge", early, 0);
    wr_n = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (wr_stb[0]) n0++;
      if (wr_stb[1]) n1++;
      if (wr_stb != 0 && first == 0) begin first = k; got = wr_data; end
    end
    chk(n0 == (a[6] ? 0 : 1) && n1 == (a[6] ? 1 : 0), "R2", "write channel pulses",
        {n1[15:0], n0[15:0]}, a[6] ? 32'h10000 : 32'h1);
    chk(first == 3, "R4", "write strobe cycle", first, 3);
    chk(got == d, "R4", "write data", got, d);
    cs_n = 1'b1; bus_in = 8'($urandom);
    repeat (3) @(negedge clk);
  endtask

  // read attempt that must produce nothing
  task automatic quiet_read(input string req);
    int n = 0, oe = 0;
    @(negedge clk); rd_n = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (rd_stb != 0 || wr_stb != 0) n++;
      if (bus_oe) oe++;
    end
    rd_n = 1'b1; wr_n = 1'b0;
    for (int k = 1; k <= 4; k++) @(negedge clk);
    wr_n = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (rd_stb != 0 || wr_stb != 0) n++;
    end
    chk(n == 0, req, "suppressed strobes", n, 0);
    chk(oe == 0, req, "suppressed oe", oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] a;
    int hi_cnt, first_hi;
    void'($urandom(32'h1234_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_stb == 0 && wr_stb == 0 && bus_oe == 0 && bus_out == 0 &&
        reg_ofs == 0 && chan_rst == 0, "R10", "reset state",
        {rd_stb, wr_stb, bus_oe, chan_rst, reg_ofs}, 0);

    // directed: both channel values and offset extremes
    run_read(8'h00);
    run_read(8'h40);
    run_write(8'hBF, 8'h5A);
    run_write(8'hFF, 8'hA5);

    // R5: chip select held high
    set_addr(8'h41);
    cs_n = 1'b1;
    quiet_read("R5");

    // R7: edges during address phase
    @(negedge clk); ale_n = 1'b0; cs_n = 1'b0; bus_in = 8'h12;
    quiet_read("R7");
    ale_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: low power
    set_addr(8'h23);
    @(negedge clk); lp_in = 1'b1;
    repeat (4) @(negedge clk);
    ale_n = 1'b0; bus_in = 8'hC5;
    repeat (4) @(negedge clk);
    ale_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(reg_ofs == exp_ofs(8'h23), "R8", "no latch in low power", reg_ofs, exp_ofs(8'h23));
    cs_n = 1'b0;
    quiet_read("R8");
    cs_n = 1'b1;

    // R9: release low power
    @(negedge clk); lp_in = 1'b0;
    hi_cnt = 0; first_hi = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (chan_rst) begin
        hi_cnt++;
        if (first_hi == 0) first_hi = k;
      end
    end
    chk(first_hi == 3, "R9", "reset pulse start", first_hi, 3);
    chk(hi_cnt == 4, "R9", "reset pulse length", hi_cnt, 4);
    chk(reg_ofs == 0, "R9", "latch cleared", reg_ofs, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      a = 8'($urandom);
      if ($urandom % 2 == 0) run_read(a);
      else run_write(a, 8'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule